// File: doc/BRIEF.md
# Next-PC Selector with Trap-Vector Fetch

This block decides where a 16-bit processor continues after each instruction. One request arrives on a valid/ready input stream. It carries the current PC, the instruction word, the one-hot condition flags (negative, zero, positive) and the value of the base register the instruction names. The block evaluates the instruction and produces one result on a valid/ready output stream. The result is the next PC and a flag that says whether control flow left the sequential path.

Three instruction classes redirect the PC:

- **Conditional PC-relative branches.** The target is taken from the adder output.
- **Register-indirect jumps.** The next PC is the base-register value.
- **Trap entries.** The block issues a read request at the zero-extended 8-bit trap vector. It then loads the PC from the word returned on a separate response stream.

Every other opcode continues at PC+1. All PC arithmetic wraps modulo 2^16.

**Back-pressure.** The input stream accepts one request only while the block is idle. `in_ready` stays low from acceptance until the result has been consumed. Each of the result, the vector request and the response transfers on a cycle where both its valid and its ready are high. A raised valid is held, with its payload unchanged, until its ready arrives.

Top module: `next_pc_unit`

## Requirements
- R1: After reset the block is idle: `in_ready` is 1, and `out_valid`, `vec_req_valid` and `vec_rsp_ready` are 0.
- R2: For opcode 0000 (bits 15:12), the mask bits 11, 10 and 9 pair with `in_flags[2]` (negative), `in_flags[1]` (zero) and `in_flags[0]` (positive). If any mask bit is 1 and its paired flag is 1, the result is `out_pc` = PC + 1 + sign-extended bits 8:0, with `out_taken` = 1.
- R3: An opcode-0000 instruction with no matching mask/flag pair gives `out_pc` = PC + 1 and `out_taken` = 0. A mask of 000 never branches, and a mask of 111 always branches under one-hot flags.
- R4: For opcode 1100, the result is `out_pc` = `in_base` and `out_taken` = 1.
- R5: Any opcode other than 0000, 1100 and 1111 gives `out_pc` = PC + 1 and `out_taken` = 0.
- R6: For opcode 1111, the block raises `vec_req_valid` with `vec_req_addr` = {8'h00, bits 7:0} and holds it until `vec_req_ready`. No result is produced before the response arrives.
- R7: After the vector request transfers, `vec_rsp_ready` is 1 until `vec_rsp_valid`. The result is then `out_pc` = `vec_rsp_data`, with `out_taken` = 1.
- R8: PC + 1 and branch targets wrap modulo 2^16.
- R9: `in_ready` is 0 from an accepted request until its result transfers. The result and the vector request stay valid and unchanged while their ready is low.
- R10: The reserved bits of a jump (11:9 and 5:0) and of a trap (11:8) do not affect the result.
- R11: For a non-trap request, `out_valid` rises in the cycle after acceptance. For a trap, it rises in the cycle after the response transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_pc | input | 16 | PC of the instruction |
| in_instr | input | 16 | Instruction word |
| in_flags | input | 3 | One-hot flags {neg, zero, pos} |
| in_base | input | 16 | Value of the base register named by bits 8:6 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_pc | output | 16 | Next PC |
| out_taken | output | 1 | Control flow redirected |
| vec_req_valid | output | 1 | Trap-vector read request valid |
| vec_req_ready | input | 1 | Memory accepts the request |
| vec_req_addr | output | 16 | Zero-extended trap-vector address |
| vec_rsp_valid | input | 1 | Read data valid |
| vec_rsp_ready | output | 1 | Block waits for read data |
| vec_rsp_data | input | 16 | Word read at the vector address |

## Verification
The assertions check the following on every cycle:

- the stream holding rules for both the result and the vector request;
- that the vector address never has upper bits set;
- that the idle, request, wait and result phases never overlap;
- that any not-taken result equals the captured PC plus one.

Only the bench scenarios can show the correctness of the target arithmetic. These scenarios cover each mask/flag pairing, offset extremes with wrap-around, jump and trap results with garbage in the reserved bits, and the exact cycle in which each result appears.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [3:0] OPC_BR   = 4'b0000;
  localparam logic [3:0] OPC_JMP  = 4'b1100;
  localparam logic [3:0] OPC_TRAP = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_OUT  = 2'd3
  } npc_state_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] flags,
  output logic              take
);
  logic [FLAG_W-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < FLAG_W; g++) begin : g_pair
      assign hit[g] = mask[g] & flags[g];
    end
  endgenerate

  assign take = |hit;

  // R3
  always_comb begin
    empty_mask_chk : assert (!(mask == '0 && take));
  end
endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 9,
  parameter int VEC_W  = 8,
  parameter int FLAG_W = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] instr,
  input  logic [FLAG_W-1:0] flags,
  input  logic [PC_W-1:0]   base,
  output logic [PC_W-1:0]   nxt_pc,
  output logic              redirect,
  output logic              is_trap,
  output logic [VEC_W-1:0]  vec
);
  localparam int OPC_LSB  = INSN_W - 4;
  localparam int MASK_LSB = OPC_LSB - FLAG_W;

  logic [3:0]        opc;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   off_ext;
  logic [PC_W-1:0]   br_tgt;
  logic              br_take;

  assign opc     = instr[INSN_W-1:OPC_LSB];
  assign pc_inc  = pc + {{(PC_W-1){1'b0}}, 1'b1};
  assign off_ext = {{(PC_W-OFF_W){instr[OFF_W-1]}}, instr[OFF_W-1:0]};
  assign br_tgt  = pc_inc + off_ext;
  assign vec     = instr[VEC_W-1:0];
  assign is_trap = (opc == OPC_TRAP);

  npc_cond_eval #(.FLAG_W(FLAG_W)) u_cond (
    .mask  (instr[OPC_LSB-1:MASK_LSB]),
    .flags (flags),
    .take  (br_take)
  );

  always_comb begin
    nxt_pc   = pc_inc;
    redirect = 1'b0;
    unique case (opc)
      OPC_BR: begin
        if (br_take) begin
          nxt_pc   = br_tgt;
          redirect = 1'b1;
        end
      end
      OPC_JMP: begin
        nxt_pc   = base;
        redirect = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int INSN_W = 16,
  parameter int OFF_W  = 9,
  parameter int VEC_W  = 8,
  parameter int FLAG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [INSN_W-1:0] in_instr,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [PC_W-1:0]   in_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PC_W-1:0]   out_pc,
  output logic              out_taken,
  output logic              vec_req_valid,
  input  logic              vec_req_ready,
  output logic [PC_W-1:0]   vec_req_addr,
  input  logic              vec_rsp_valid,
  output logic              vec_rsp_ready,
  input  logic [PC_W-1:0]   vec_rsp_data
);
  npc_state_e        state_q;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   res_pc_q;
  logic              res_taken_q;
  logic [VEC_W-1:0]  vec_q;

  logic [PC_W-1:0]   calc_pc;
  logic              calc_redirect;
  logic              calc_trap;
  logic [VEC_W-1:0]  calc_vec;

  npc_target_calc #(
    .PC_W(PC_W), .INSN_W(INSN_W), .OFF_W(OFF_W), .VEC_W(VEC_W), .FLAG_W(FLAG_W)
  ) u_calc (
    .pc       (in_pc),
    .instr    (in_instr),
    .flags    (in_flags),
    .base     (in_base),
    .nxt_pc   (calc_pc),
    .redirect (calc_redirect),
    .is_trap  (calc_trap),
    .vec      (calc_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pc_q        <= '0;
      res_pc_q    <= '0;
      res_taken_q <= 1'b0;
      vec_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            pc_q <= in_pc;
            if (calc_trap) begin
              vec_q   <= calc_vec;
              state_q <= ST_REQ;
            end else begin
              res_pc_q    <= calc_pc;
              res_taken_q <= calc_redirect;
              state_q     <= ST_OUT;
            end
          end
        end
        ST_REQ: if (vec_req_ready) state_q <= ST_RSP;
        ST_RSP: begin
          if (vec_rsp_valid) begin
            res_pc_q    <= vec_rsp_data;
            res_taken_q <= 1'b1;
            state_q     <= ST_OUT;
          end
        end
        ST_OUT: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready      = (state_q == ST_IDLE);
  assign vec_req_valid = (state_q == ST_REQ);
  assign vec_rsp_ready = (state_q == ST_RSP);
  assign out_valid     = (state_q == ST_OUT);
  assign out_pc        = res_pc_q;
  assign out_taken     = res_taken_q;
  assign vec_req_addr  = {{(PC_W-VEC_W){1'b0}}, vec_q};

  // R9
  out_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_taken));

  // R9
  req_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_valid && !vec_req_ready |=> vec_req_valid && $stable(vec_req_addr));

  // R6
  vec_zext_chk : assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_valid |-> vec_req_addr[PC_W-1:VEC_W] == '0);

  // R7
  rsp_phase_chk : assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_ready, vec_req_valid, vec_rsp_ready, out_valid}) == 1);

  // R3
  seq_pc_chk : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_pc == (pc_q + {{(PC_W-1){1'b0}}, 1'b1}));
endmodule

// File: tb/tb_next_pc_unit.sv
module tb_next_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pc = '0;
  logic [15:0] in_instr = '0;
  logic [2:0]  in_flags = 3'b010;
  logic [15:0] in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_pc;
  logic        out_taken;
  logic        vec_req_valid;
  logic        vec_req_ready = 1'b0;
  logic [15:0] vec_req_addr;
  logic        vec_rsp_valid = 1'b0;
  logic        vec_rsp_ready;
  logic [15:0] vec_rsp_data = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  next_pc_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc), .in_instr(in_instr),
    .in_flags(in_flags), .in_base(in_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_taken(out_taken),
    .vec_req_valid(vec_req_valid), .vec_req_ready(vec_req_ready), .vec_req_addr(vec_req_addr),
    .vec_rsp_valid(vec_rsp_valid), .vec_rsp_ready(vec_rsp_ready), .vec_rsp_data(vec_rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] expect_npc(input logic [15:0] pc, input logic [15:0] ins,
                                             input logic [2:0] fl, input logic [15:0] base,
                                             input logic [15:0] rsp);
    logic [15:0] inc;
    inc = pc + 16'd1;
    case (ins[15:12])
      4'h0: begin
        if (|(ins[11:9] & fl)) return {1'b1, inc + {{7{ins[8]}}, ins[8:0]}};
        return {1'b0, inc};
      end
      4'hC: return {1'b1, base};
      4'hF: return {1'b1, rsp};
      default: return {1'b0, inc};
    endcase
  endfunction

  task automatic run_op(input logic [15:0] pc, input logic [15:0] ins, input logic [2:0] fl,
                        input logic [15:0] base, input logic [15:0] rsp,
                        input int req_stall, input int rsp_delay, input int out_stall,
                        input string tag);
    logic [16:0] exp;
    exp = expect_npc(pc, ins, fl, base, rsp);
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 idle ready", 32'(in_ready), 32'd1);
    in_valid = 1'b1; in_pc = pc; in_instr = ins; in_flags = fl; in_base = base;
    @(negedge clk);
    in_valid = 1'b0; in_instr = $urandom; in_base = $urandom;
    if (ins[15:12] == 4'hF) begin
      chk(vec_req_valid && vec_req_addr == {8'h00, ins[7:0]}, "R6 vector request",
          {15'd0, vec_req_valid, vec_req_addr}, {15'd0, 1'b1, 8'h00, ins[7:0]});
      chk(out_valid == 1'b0, "R6 no early result", 32'(out_valid), 32'd0);
      for (int i = 0; i < req_stall; i++) begin
        @(negedge clk);
        chk(vec_req_valid && vec_req_addr == {8'h00, ins[7:0]}, "R9 request held",
            {15'd0, vec_req_valid, vec_req_addr}, {15'd0, 1'b1, 8'h00, ins[7:0]});
      end
      vec_req_ready = 1'b1;
      @(negedge clk);
      vec_req_ready = 1'b0;
      chk(vec_rsp_ready && !vec_req_valid, "R7 waiting for data",
          {vec_rsp_ready, vec_req_valid}, 32'd2);
      for (int i = 0; i < rsp_delay; i++) begin
        @(negedge clk);
        chk(vec_rsp_ready && !out_valid, "R7 still waiting", {vec_rsp_ready, out_valid}, 32'd2);
      end
      vec_rsp_valid = 1'b1; vec_rsp_data = rsp;
      @(negedge clk);
      vec_rsp_valid = 1'b0; vec_rsp_data = $urandom;
    end
    chk(out_valid == 1'b1, "R11 result cycle", 32'(out_valid), 32'd1);
    chk({out_taken, out_pc} == exp, tag, {15'd0, out_taken, out_pc}, {15'd0, exp});
    chk(in_ready == 1'b0, "R9 busy", 32'(in_ready), 32'd0);
    for (int i = 0; i < out_stall; i++) begin
      @(negedge clk);
      chk(out_valid && {out_taken, out_pc} == exp, "R9 result held",
          {14'd0, out_valid, out_taken, out_pc}, {14'd0, 1'b1, exp});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9 back to idle", {out_valid, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] fl;
    logic [15:0] ins;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !vec_req_valid && !vec_rsp_ready, "R1 reset state",
        {in_ready, out_valid, vec_req_valid, vec_rsp_ready}, 32'd8);

    // R2 / R3: every mask against every one-hot flag
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 3; f++) begin
        fl = 3'b001 << f;
        ins = {4'h0, 3'(m), 9'h005};
        run_op(16'h3000, ins, fl, 16'h0, 16'h0, 0, 0, 0,
               ((m & (1 << f)) != 0) ? "R2 branch taken" : "R3 branch not taken");
      end
    end
    run_op(16'h4000, 16'h01FF, 3'b010, 0, 0, 0, 0, 1, "R3 zero mask");
    run_op(16'h4000, 16'h0FFF, 3'b100, 0, 0, 0, 0, 0, "R3 full mask");
    run_op(16'h1000, 16'h0EFF, 3'b001, 0, 0, 0, 0, 0, "R2 max offset");
    run_op(16'h1000, 16'h0F00, 3'b001, 0, 0, 0, 0, 0, "R2 min offset");
    run_op(16'hFFFF, 16'h1234, 3'b001, 0, 0, 0, 0, 0, "R8 wrap increment");
    run_op(16'h0000, 16'h0FFD, 3'b001, 0, 0, 0, 0, 0, "R8 wrap backward branch");
    run_op(16'hFFFE, 16'h0E05, 3'b100, 0, 0, 0, 0, 0, "R8 wrap forward branch");
    run_op(16'h2000, 16'hC140, 3'b010, 16'hBEEF, 0, 0, 0, 2, "R4 jump");
    run_op(16'h2000, 16'hCF7F, 3'b010, 16'h1357, 0, 0, 0, 0, "R10 jump reserved bits");
    run_op(16'h5000, 16'h5123, 3'b100, 16'h9999, 0, 0, 0, 0, "R5 other opcode");
    run_op(16'h5000, 16'hE1FF, 3'b001, 16'h9999, 0, 0, 0, 0, "R5 other opcode");
    run_op(16'h3000, 16'hF025, 3'b010, 0, 16'h0520, 0, 0, 0, "R7 trap result");
    run_op(16'h3000, 16'hF0FF, 3'b010, 0, 16'hABCD, 3, 2, 2, "R7 trap stalled");
    run_op(16'h3000, 16'hFA21, 3'b010, 0, 16'h0777, 1, 1, 0, "R10 trap reserved bits");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] opc;
      case ($urandom % 5)
        0, 1: opc = 4'h0;
        2: opc = 4'hC;
        3: opc = 4'hF;
        default: opc = 4'($urandom);
      endcase
      fl = 3'b001 << ($urandom % 3);
      ins = {opc, 12'($urandom)};
      run_op(16'($urandom), ins, fl, 16'($urandom), 16'($urandom),
             $urandom % 3, $urandom % 3, $urandom % 3,
             (opc == 4'h0) ? "R2 random branch" : (opc == 4'hC) ? "R4 random jump" :
             (opc == 4'hF) ? "R7 random trap" : "R5 random other");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule